// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a small accumulator-style core that uses 14-bit instruction words. It holds a 13-bit program counter, a 5-bit upper-address latch written by software, an eight-entry return-address stack and the global interrupt enable flag. On every clock the counter either moves to the next word or is redirected by one of several sources: an accepted interrupt, a subroutine or interrupt return, an in-page jump or call, or a computed write to the low byte of the counter.

The core's decoder supplies one-cycle control strobes, a jump or call target and the written data. In-page transfers carry 11 target bits. Bits 4:3 of the latch complete the page number. A computed write takes its upper five bits from the whole latch. A reset sends the counter to address zero, and an accepted interrupt sends it to address four.

Top module: `pcseq_top`

## Requirements
- R1: While `rst_ni` is low, `pc_o`, `lath_o` and `gie_o` are all zero.
- R2: With no strobe active, `pc_o` advances by one per clock and wraps from 1FFFh to 0000h.
- R3: `goto_i` loads `pc_o` with {`lath_o`[4:3], `tgt_i`[10:0]}. The stack is not touched.
- R4: `call_i` loads the same target as R3 and pushes the value `pc_o`+1.
- R5: `pcl_wr_i` loads `pc_o` with {`lath_o`[4:0], `pcl_data_i`[7:0]}. The latch value used is the one held before any latch write in the same cycle.
- R6: `lath_wr_i` loads `lath_o` from `lath_data_i` on the next clock. Without that strobe, `lath_o` holds its value through returns and interrupts.
- R7: `ret_i` loads `pc_o` with the most recently pushed address that has not yet been popped.
- R8: The stack holds 8 entries and works as a ring. A ninth push overwrites the oldest entry. A pop from an empty stack wraps to the newest slot of the ring. No flag is raised in either case.
- R9: An interrupt is accepted when `irq_i` and `gie_o` are both high. Acceptance pushes `pc_o`+1, loads 0004h and clears `gie_o`. When `gie_o` is low, `irq_i` has no effect.
- R10: `retfie_i` pops the stack into `pc_o` like R7 and sets `gie_o`.
- R11: When strobes coincide, the priority is: accepted interrupt, then return (either kind), then call, then goto, then low-byte write. Only the winning strobe changes the counter or the stack.
- R12: `gie_wr_i` loads `gie_o` from `gie_data_i`, unless an accepted interrupt or a `retfie_i` decides the flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request |
| goto_i | input | 1 | In-page jump strobe |
| call_i | input | 1 | In-page call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| pcl_wr_i | input | 1 | Low PC byte write strobe |
| tgt_i | input | 11 | Jump or call target within the page |
| pcl_data_i | input | 8 | Data written to the low PC byte |
| lath_wr_i | input | 1 | Upper-address latch write strobe |
| lath_data_i | input | 5 | Upper-address latch write data |
| gie_wr_i | input | 1 | Interrupt enable write strobe |
| gie_data_i | input | 1 | Interrupt enable write data |
| pc_o | output | 13 | Fetch address |
| lath_o | output | 5 | Upper-address latch value |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The two functions that most often meet in one clock are interrupt acceptance and a call: both want to push, and both want to load the counter. The bench raises `irq_i` with `gie_o` set in the same cycle as `call_i`, and also combines `irq_i` with returns and low-byte writes. It then expects exactly one push of `pc_o`+1, a fetch from 0004h and a cleared enable, as R11 requires. A second collision is a latch write together with a low-byte write. Here the new PC must use the old latch value. The latch itself must show the new value on the next clock.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    SEL_INC = 3'd0,
    SEL_VEC = 3'd1,
    SEL_POP = 3'd2,
    SEL_JMP = 3'd3,
    SEL_PCL = 3'd4
  } pc_sel_e;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic    irq_i,
  input  logic    gie_i,
  input  logic    goto_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    retfie_i,
  input  logic    pcl_wr_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    pop_o,
  output logic    take_o,
  output logic    rfi_o
);
  always_comb begin
    sel_o  = SEL_INC;
    push_o = 1'b0;
    pop_o  = 1'b0;
    take_o = 1'b0;
    rfi_o  = 1'b0;
    if (irq_i && gie_i) begin
      sel_o  = SEL_VEC;
      push_o = 1'b1;
      take_o = 1'b1;
    end else if (ret_i || retfie_i) begin
      sel_o = SEL_POP;
      pop_o = 1'b1;
      rfi_o = retfie_i;
    end else if (call_i) begin
      sel_o  = SEL_JMP;
      push_o = 1'b1;
    end else if (goto_i) begin
      sel_o = SEL_JMP;
    end else if (pcl_wr_i) begin
      sel_o = SEL_PCL;
    end
  end
endmodule

// File: rtl/pcseq_latch.sv
module pcseq_latch #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= data_i;
  end

  AST_LATH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o)) else $error("latch changed without write"); // R6
  AST_LATH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(data_i)) else $error("latch write lost"); // R6
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o
);
  // ring buffer: DEPTH must be a power of two, wrap is free
  localparam int SPW = $clog2(DEPTH);

  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  mem_q [DEPTH];
  logic [SPW-1:0] rd_idx;

  assign rd_idx = sp_q - SPW'(1);
  assign top_o  = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + SPW'(1);
    else if (pop_i)  sp_q <= rd_idx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (push_i && sp_q == SPW'(g))   mem_q[g] <= push_data_i;
    end
  end

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_data_i)) else $error("push not on top"); // R8
  AST_IDLE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(top_o)) else $error("stack moved when idle"); // R8
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PW     = 13,
  parameter int PAGE_W = 11,
  parameter int DEPTH  = 8,
  parameter int VEC    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              goto_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              retfie_i,
  input  logic              pcl_wr_i,
  input  logic [PAGE_W-1:0] tgt_i,
  input  logic [7:0]        pcl_data_i,
  input  logic              lath_wr_i,
  input  logic [PW-9:0]     lath_data_i,
  input  logic              gie_wr_i,
  input  logic              gie_data_i,
  output logic [PW-1:0]     pc_o,
  output logic [PW-9:0]     lath_o,
  output logic              gie_o
);
  localparam int PCL_W = 8;
  localparam int LW    = PW - PCL_W;
  localparam int HI_W  = PW - PAGE_W;
  localparam logic [PW-1:0] VEC_IRQ = PW'(VEC);

  pc_sel_e       sel;
  logic          push, pop, take, rfi;
  logic [PW-1:0] pc_inc, pc_nxt, stk_top;

  pcseq_ctrl u_ctrl (
    .irq_i(irq_i), .gie_i(gie_o), .goto_i(goto_i), .call_i(call_i),
    .ret_i(ret_i), .retfie_i(retfie_i), .pcl_wr_i(pcl_wr_i),
    .sel_o(sel), .push_o(push), .pop_o(pop), .take_o(take), .rfi_o(rfi)
  );

  pcseq_latch #(.W(LW)) u_lath (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(lath_wr_i),
    .data_i(lath_data_i), .q_o(lath_o)
  );

  pcseq_stack #(.AW(PW), .DEPTH(DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_data_i(pc_inc), .top_o(stk_top)
  );

  assign pc_inc = pc_o + PW'(1);

  always_comb begin
    unique case (sel)
      SEL_VEC: pc_nxt = VEC_IRQ;
      SEL_POP: pc_nxt = stk_top;
      SEL_JMP: pc_nxt = {lath_o[LW-1 -: HI_W], tgt_i};
      SEL_PCL: pc_nxt = {lath_o, pcl_data_i};
      default: pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= '0;
    else         pc_o <= pc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gie_o <= 1'b0;
    else if (take)     gie_o <= 1'b0;
    else if (rfi)      gie_o <= 1'b1;
    else if (gie_wr_i) gie_o <= gie_data_i;
  end

  logic quiet;
  assign quiet = !(irq_i && gie_o) && !ret_i && !retfie_i && !call_i && !goto_i && !pcl_wr_i;

  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && gie_o) |=> (pc_o == VEC_IRQ && !gie_o)) else $error("irq vector"); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !gie_wr_i) |=> $stable(gie_o)) else $error("gie moved"); // R9
  AST_RETFIE_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retfie_i && !(irq_i && gie_o)) |=> gie_o) else $error("retfie gie"); // R10
  AST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> pc_o == $past(pc_o) + PW'(1)) else $error("increment"); // R2
  AST_PCL_OLD_LATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_wr_i && !(irq_i && gie_o) && !ret_i && !retfie_i && !call_i && !goto_i)
    |=> pc_o == {$past(lath_o), $past(pcl_data_i)}) else $error("pcl write"); // R5
  AST_IRQ_BEATS_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && gie_o && call_i) |=> pc_o == VEC_IRQ) else $error("priority"); // R11
endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 0, go = 0, call = 0, ret = 0, rfi = 0, pclw = 0;
  logic [10:0] tgt = '0;
  logic [7:0]  pcld = '0;
  logic        lwr = 0;
  logic [4:0]  ldat = '0;
  logic        gwr = 0, gdat = 0;
  logic [12:0] pc;
  logic [4:0]  lath;
  logic        gie;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_pc = 0, m_lath = 0, m_gie = 0, m_sp = 0;
  int m_stk [8];
  string op_tag;

  always #5 clk = ~clk;

  pcseq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .goto_i(go), .call_i(call),
    .ret_i(ret), .retfie_i(rfi), .pcl_wr_i(pclw), .tgt_i(tgt),
    .pcl_data_i(pcld), .lath_wr_i(lwr), .lath_data_i(ldat),
    .gie_wr_i(gwr), .gie_data_i(gdat), .pc_o(pc), .lath_o(lath), .gie_o(gie)
  );

  task automatic m_push(int v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  task automatic model_update();
    int nxt, take, rfi_sel;
    nxt = (m_pc + 1) & 'h1FFF;
    take = irq && (m_gie != 0);
    rfi_sel = 0;
    if (take) begin
      m_push(nxt); m_pc = 4; op_tag = "R9/R11";
    end else if (ret || rfi) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
      rfi_sel = rfi; op_tag = rfi ? "R10" : "R7";
    end else if (call) begin
      m_push(nxt); m_pc = (((m_lath >> 3) & 3) << 11) | int'(tgt); op_tag = "R4";
    end else if (go) begin
      m_pc = (((m_lath >> 3) & 3) << 11) | int'(tgt); op_tag = "R3";
    end else if (pclw) begin
      m_pc = (m_lath << 8) | int'(pcld); op_tag = "R5";
    end else begin
      m_pc = nxt; op_tag = "R2";
    end
    if (take) m_gie = 0;
    else if (rfi_sel) m_gie = 1;
    else if (gwr) m_gie = int'(gdat);
    if (lwr) m_lath = int'(ldat);
  endtask

  task automatic compare(string ctx);
    n_cmp++;
    if (int'(pc) != m_pc || int'(lath) != m_lath || int'(gie) != m_gie) begin
      n_bad++;
      $display("FAIL %s (%s): pc=%h lath=%h gie=%0d expected pc=%h lath=%h gie=%0d",
               ctx, op_tag, pc, lath, gie, m_pc[12:0], m_lath[4:0], m_gie);
    end
  endtask

  task automatic idle_in();
    irq = 0; go = 0; call = 0; ret = 0; rfi = 0; pclw = 0; lwr = 0; gwr = 0;
  endtask

  task automatic step(string ctx);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(ctx);
    idle_in();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    op_tag = "R1";
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    step("R2 first inc");
    step("R2 inc");

    // gie low: irq ignored
    irq = 1; step("R9 masked irq");
    // latch write then goto/call
    lwr = 1; ldat = 5'h1A; step("R6 latch write");
    go = 1; tgt = 11'h123; step("R3 goto page");
    call = 1; tgt = 11'h7FF; step("R4 call");
    ret = 1; step("R7 ret");
    // computed write collides with latch write: old latch used
    pclw = 1; pcld = 8'h5C; lwr = 1; ldat = 5'h07; step("R5 pcl old lath");
    step("R6 latch new");
    // wrap at top of memory
    lwr = 1; ldat = 5'h1F; step("R6 latch 1F");
    pclw = 1; pcld = 8'hFF; step("R5 pcl to 1FFF");
    step("R2 wrap");
    // nine calls then ten returns: ring overwrite and empty wrap
    for (int i = 0; i < 9; i++) begin
      call = 1; tgt = 11'(16 * i + 1); step("R8 push");
    end
    for (int i = 0; i < 10; i++) begin
      ret = 1; step("R8 pop");
    end
    // enable, irq colliding with call
    gwr = 1; gdat = 1; step("R12 gie set");
    irq = 1; call = 1; tgt = 11'h055; step("R11 irq vs call");
    irq = 1; step("R9 irq while masked");
    lwr = 1; ldat = 5'h03; step("R6 latch in isr");
    rfi = 1; gwr = 1; gdat = 0; step("R10 retfie beats gie write");
    irq = 1; ret = 1; step("R11 irq vs ret");
    rfi = 1; step("R10 retfie");
    gwr = 1; gdat = 0; step("R12 gie clear");

    // random mix with collisions
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      irq  = ($urandom_range(0, 7) == 0);
      go   = (r == 1) || (r == 9);
      call = (r == 2) || (r == 9);
      ret  = (r == 3);
      rfi  = (r == 4);
      pclw = (r == 5) || (r == 10);
      lwr  = (r == 6) || (r == 10);
      gwr  = (r == 7);
      gdat = 1'($urandom_range(0, 1));
      tgt  = 11'($urandom);
      pcld = 8'($urandom);
      ldat = 5'($urandom);
      step("R11 random");
    end

    rst_n = 1'b0;
    m_pc = 0; m_lath = 0; m_gie = 0; m_sp = 0; op_tag = "R1";
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    #1;
    compare("R1 async reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule